// File: doc/BRIEF.md
# Dithered sub-cycle PWM generator

This block drives a single pulse-width output from an 8-bit duty word. A free-running 256-clock cycle is cut into equal sub-cycles, so the output toggles several times per cycle instead of once; a load with a long time constant sees the same average level but much less ripple. The duty word is split into a coarse part, which sets the high time of every sub-cycle, and a small fractional part, which lends one extra high clock to the leading sub-cycles so the total high time over the cycle still equals the duty word.

Two cut modes are offered. Mode 0 uses four sub-cycles of 64 clocks (coarse = upper six duty bits, fraction = lower two). Mode 1 uses two sub-cycles of 128 clocks (coarse = upper seven bits, fraction = lowest bit). Duty and mode are captured only at the first clock of a cycle, so software may write them at any time without glitching the running cycle. A one-clock strobe marks each cycle start.

Top module: `subcycle_pwm`

## Requirements
- R1: While enabled, a cycle lasts exactly 256 clocks; `cyc_start` is high for one clock, in the same clock as the output value for cycle position 0, and low for the other 255 positions. Both outputs are registered: the value for a position appears one clock after the edge that processes it.
- R2: In mode 0 (`mode`=0), position k lies in sub-cycle i = k/64; the high count of sub-cycle i is duty[7:2] plus one when i < duty[1:0], else duty[7:2]. Duty 100, 101, 102, 103 give high counts 25/25/25/25, 26/25/25/25, 26/26/25/25, 26/26/26/25.
- R3: Within each sub-cycle the output is high from the first clock of the sub-cycle for exactly the high count, then low until the sub-cycle ends.
- R4: In mode 1 (`mode`=1), sub-cycle i = k/128 has high count duty[7:1] plus one when i < duty[0], else duty[7:1]; duty 101 gives 51/50.
- R5: Values of `duty` and `mode` present at the first clock of a cycle govern the whole cycle; changes made later in the cycle have no effect until the next cycle start.
- R6: While `en` is low, `pwm_out` and `cyc_start` are low and the position counter is held at zero, so the first enabled clock begins a fresh cycle at position 0 with `cyc_start` high.
- R7: Synchronous active-high `rst` clears the counter, the captured duty and mode, and drives both outputs low one clock later.
- R8: Duty 0 keeps the output low for the whole cycle; duty 255 in mode 0 gives 64/64/64/63 high clocks and in mode 1 gives 128/127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the PWM count clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the counter at zero and the output low |
| mode | input | 1 | 0: four 64-clock sub-cycles, 1: two 128-clock sub-cycles |
| duty | input | 8 | Duty word, sampled at each cycle start |
| pwm_out | output | 1 | Registered PWM output |
| cyc_start | output | 1 | One-clock strobe on the first position of every cycle |

## Verification
The cycle-start capture and a write of new duty or mode can land in the same clock: the bench changes both inputs in the middle of cycles and also right before a cycle boundary, and judges every position of the running cycle against values computed from the word captured at the strobe, never the newest write. A second collision is an enable drop or a reset arriving mid-cycle while the output is high; the bench then requires an immediate low output and a restart at position 0 with the strobe on the first enabled clock. Shapes of random and directed duty words are compared position by position, and the per-sub-cycle high counts are checked against the explicit figures in the requirements.

// File: rtl/subpwm_pkg.sv
package subpwm_pkg;
  // Width of the position counter; a full cycle is 2**CYC_W clocks.
  localparam int CYC_W = 8;
  // Fraction widths of the two cut modes.
  localparam int FRAC_QUAD = 2;
  localparam int FRAC_HALF = 1;

  typedef enum logic {
    CUT_QUAD = 1'b0,
    CUT_HALF = 1'b1
  } cut_mode_e;
endpackage

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CYC_W-1:0] pos,
  output logic             first
);
  localparam logic [CYC_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst || !en) pos <= '0;
    else            pos <= pos + 1'b1;
  end

  assign first = en && (pos == '0);

  // R1: position wraps from the last value back to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (en && pos == LAST) |=> (pos == '0));

  // R6: counter held at zero while disabled
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pos == '0));
endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic [CYC_W-1:0] duty_in,
  input  logic             mode_in,
  output logic [CYC_W-1:0] duty_eff,
  output logic             mode_eff
);
  logic [CYC_W-1:0] duty_q;
  logic             mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      mode_q <= 1'b0;
    end else if (first) begin
      duty_q <= duty_in;
      mode_q <= mode_in;
    end
  end

  // At a cycle start the fresh inputs are used directly, later positions
  // use the captured copy.
  assign duty_eff = first ? duty_in : duty_q;
  assign mode_eff = first ? mode_in : mode_q;

  // R5: captured settings stay put between cycle starts
  p_hold_settings_r5: assert property (@(posedge clk) disable iff (rst)
    !first |=> ($stable(duty_q) && $stable(mode_q)));
endmodule

// File: rtl/pwm_subcycle_compare.sv
module pwm_subcycle_compare #(
  parameter int CYC_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic [CYC_W-1:0] pos,
  input  logic [CYC_W-1:0] duty,
  output logic             high
);
  localparam int OFS_W = CYC_W - FRAC_W;

  logic [FRAC_W-1:0] sub_idx;
  logic [FRAC_W-1:0] frac;
  logic [OFS_W-1:0]  offset;
  logic [OFS_W-1:0]  coarse;
  logic [OFS_W:0]    hi_len;

  always_comb begin
    sub_idx = pos[CYC_W-1 -: FRAC_W];
    offset  = pos[OFS_W-1:0];
    coarse  = duty[CYC_W-1 -: OFS_W];
    frac    = duty[FRAC_W-1:0];
    // Leading sub-cycles below the fraction get one extra high clock.
    hi_len  = {1'b0, coarse} + {{OFS_W{1'b0}}, (sub_idx < frac)};
    high    = ({1'b0, offset} < hi_len);
  end
endmodule

// File: rtl/subcycle_pwm.sv
module subcycle_pwm
  import subpwm_pkg::*;
#(
  parameter int CNT_W = CYC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out,
  output logic             cyc_start
);
  localparam int NUM_CUTS = 2;

  logic [CNT_W-1:0]    pos;
  logic                first;
  logic [CNT_W-1:0]    duty_eff;
  logic                mode_eff;
  logic [NUM_CUTS-1:0] cut_high;

  pwm_cycle_counter #(.CYC_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .pos   (pos),
    .first (first)
  );

  pwm_duty_latch #(.CYC_W(CNT_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .first    (first),
    .duty_in  (duty),
    .mode_in  (mode),
    .duty_eff (duty_eff),
    .mode_eff (mode_eff)
  );

  // One comparator per cut mode; index follows cut_mode_e encoding.
  for (genvar g = 0; g < NUM_CUTS; g++) begin : g_cut
    localparam int FW = (g == int'(CUT_QUAD)) ? FRAC_QUAD : FRAC_HALF;
    pwm_subcycle_compare #(.CYC_W(CNT_W), .FRAC_W(FW)) u_cmp (
      .pos  (pos),
      .duty (duty_eff),
      .high (cut_high[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pwm_out   <= 1'b0;
      cyc_start <= 1'b0;
    end else begin
      pwm_out   <= cut_high[mode_eff];
      cyc_start <= first;
    end
  end

  // R1: strobe is a single-clock pulse
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);

  // R6: output low after a disabled clock
  p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && !cyc_start));

  // R7: reset drives outputs low
  p_reset_low_r7: assert property (@(posedge clk)
    rst |=> (!pwm_out && !cyc_start));

  // R8: zero duty never raises the output
  p_zero_duty_low_r8: assert property (@(posedge clk) disable iff (rst)
    (en && duty_eff == '0) |=> !pwm_out);
endmodule

// File: tb/tb_subcycle_pwm.sv
module tb_subcycle_pwm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       pwm_out;
  logic       cyc_start;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  subcycle_pwm dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .duty(duty),
    .pwm_out(pwm_out), .cyc_start(cyc_start)
  );

  function automatic bit exp_level(input int d, input bit m, input int k);
    int nsub = m ? 2 : 4;
    int len  = 256 / nsub;
    int i    = k / len;
    int p    = k % len;
    int dc   = d / nsub;
    int ac   = d % nsub;
    int hi   = dc + ((i < ac) ? 1 : 0);
    return (p < hi);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Runs one full cycle. Settings are applied before its first edge;
  // optionally scrambled mid-cycle (must not matter).
  task automatic do_cycle(input int d, input bit m, input bit scramble,
                          input bit use_cnt, input int e0, input int e1,
                          input int e2, input int e3, input string req);
    int cnt[4];
    int bad_k = -1;
    int bad_act = 0;
    int bad_exp = 0;
    bit strobe_ok = 1'b1;
    duty = d[7:0];
    mode = m;
    for (int q = 0; q < 4; q++) cnt[q] = 0;
    for (int k = 0; k < 256; k++) begin
      step();
      if (cyc_start !== (k == 0)) strobe_ok = 1'b0;
      if (pwm_out !== exp_level(d, m, k) && bad_k < 0) begin
        bad_k = k; bad_act = pwm_out; bad_exp = exp_level(d, m, k);
      end
      if (pwm_out === 1'b1) cnt[m ? k / 128 : k / 64]++;
      if (scramble && (k == 90 || k == 255)) begin
        duty = 8'($urandom);
        mode = 1'($urandom);
      end
    end
    check(strobe_ok, "R1", "strobe placement", strobe_ok, 1);
    check(bad_k < 0, req, $sformatf("shape d=%0d m=%0d first bad pos %0d", d, m, bad_k),
          bad_act, bad_exp);
    if (scramble)
      check(bad_k < 0, "R5", "mid-cycle write leaked", bad_act, bad_exp);
    if (use_cnt) begin
      check(cnt[0] == e0, req, "high count sub0", cnt[0], e0);
      check(cnt[1] == e1, req, "high count sub1", cnt[1], e1);
      if (!m) begin
        check(cnt[2] == e2, req, "high count sub2", cnt[2], e2);
        check(cnt[3] == e3, req, "high count sub3", cnt[3], e3);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    duty = 8'd255;
    repeat (3) step();
    check(pwm_out === 1'b0 && cyc_start === 1'b0, "R7", "reset outputs",
          {pwm_out, cyc_start}, 0);
    rst = 1'b0;
    step();
    check(pwm_out === 1'b0 && cyc_start === 1'b0, "R6", "idle while disabled",
          {pwm_out, cyc_start}, 0);
    en = 1'b1;

    // R2 R3 directed
    do_cycle(100, 0, 0, 1, 25, 25, 25, 25, "R2");
    do_cycle(101, 0, 0, 1, 26, 25, 25, 25, "R2");
    do_cycle(102, 0, 0, 1, 26, 26, 25, 25, "R2");
    do_cycle(103, 0, 0, 1, 26, 26, 26, 25, "R3");
    // R4 directed
    do_cycle(101, 1, 0, 1, 51, 50, 0, 0, "R4");
    do_cycle(100, 1, 0, 1, 50, 50, 0, 0, "R4");
    // R8 extremes
    do_cycle(0, 0, 0, 1, 0, 0, 0, 0, "R8");
    do_cycle(255, 0, 0, 1, 64, 64, 64, 63, "R8");
    do_cycle(255, 1, 0, 1, 128, 127, 0, 0, "R8");
    do_cycle(0, 1, 0, 1, 0, 0, 0, 0, "R8");
    do_cycle(1, 0, 0, 1, 1, 0, 0, 0, "R3");

    // R5 mid-cycle writes, plus random shapes
    for (int n = 0; n < 16; n++) begin
      int d = int'(8'($urandom));
      bit m = 1'($urandom);
      do_cycle(d, m, (n % 2) == 0, 0, 0, 0, 0, 0, m ? "R4" : "R2");
    end

    // R6 disable mid-cycle with output high
    duty = 8'd255; mode = 1'b0;
    repeat (40) step();
    check(pwm_out === 1'b1, "R6", "output high before disable", pwm_out, 1);
    en = 1'b0;
    for (int n = 0; n < 5; n++) begin
      step();
      check(pwm_out === 1'b0 && cyc_start === 1'b0, "R6", "disabled outputs",
            {pwm_out, cyc_start}, 0);
    end
    en = 1'b1;
    do_cycle(103, 0, 0, 1, 26, 26, 26, 25, "R6");

    // R7 reset mid-cycle
    duty = 8'd255;
    repeat (70) step();
    rst = 1'b1;
    step();
    check(pwm_out === 1'b0 && cyc_start === 1'b0, "R7", "reset mid-cycle",
          {pwm_out, cyc_start}, 0);
    rst = 1'b0;
    do_cycle(201, 1, 0, 1, 101, 100, 0, 0, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule